// File: doc/BRIEF.md
# Lock-gated audio serial clock generator

This block derives the bit clock, the frame clock and the master clock of an audio converter's serial port from one internal clock, which is assumed to run at 256 times the sample rate. Control inputs set the PLL and converter power bits, the role (clock master or clock slave), the bit clock ratio and the master clock output enable. A separate input reports PLL lock, and it is assumed to be synchronous to the internal clock.

As clock master the block drives the bit clock and frame clock pins. They stay low until the block is powered and the PLL reports lock. They then start from the beginning of a frame, so the first period is full length. A loss of lock or power returns them to low, and the next lock starts a fresh frame. A change to the bit clock ratio is held back until the next frame boundary. As clock slave the two pins are released as inputs. In either role the master clock output is a divided copy of the internal clock whenever the block is powered and the output is enabled. It does not wait for lock.

Top module: `audio_clkgen_top`

## Requirements
- R1: The block is powered only while `pwr_pll` and `pwr_dac` are both 1. When it is not powered, `bclk_o`, `lrck_o` and `mclk_o` are 0 one cycle later.
- R2: `bclk_oe` and `lrck_oe` are 1 while `master_sel` is 1 and 0 while it is 0. They follow it in the same cycle.
- R3: In master mode with power on and `pll_locked` at 0, `bclk_o` and `lrck_o` are 0 from the following cycle on.
- R4: Count n = 0 in the first cycle after the clock edge at which the block is powered, in master mode and locked for the first time. From that cycle, `lrck_o` equals bit 7 of (n mod 256). So the frame is 256 internal clock cycles long and starts with a low half.
- R5: With the active ratio at 1, `bclk_o` equals bit 1 of (n mod 256), which is 64 bit clocks per frame. With the active ratio at 0 it equals bit 2, which is 32 bit clocks per frame.
- R6: The active ratio takes the value of `bclk64_sel` at the clock edge that starts counting. After that it takes the value only at an edge where n mod 256 = 255, so the new ratio applies from the first cycle of the next frame.
- R7: If lock or power is lost while running, `bclk_o` and `lrck_o` are 0 in the following cycle. The next lock restarts the count at n = 0.
- R8: While `mclk_en` is 0, `mclk_o` is 0 from the following cycle on, in every mode and lock state.
- R9: While the block is powered and `mclk_en` is 1, `mclk_o` inverts at every internal clock edge, whatever the role and the lock state. After being held at 0 its first value is 1.
- R10: In slave mode the bit clock and frame clock output values are held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock, 256 times the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_pll | input | 1 | PLL power bit |
| pwr_dac | input | 1 | Converter power bit |
| master_sel | input | 1 | 1 = clock master, 0 = clock slave |
| bclk64_sel | input | 1 | Requested bit clock ratio: 1 = 64x, 0 = 32x the frame rate |
| mclk_en | input | 1 | Master clock output enable |
| pll_locked | input | 1 | PLL lock indication, synchronous to clk |
| bclk_o | output | 1 | Bit clock output value |
| bclk_oe | output | 1 | Bit clock pin output enable |
| lrck_o | output | 1 | Frame clock output value |
| lrck_oe | output | 1 | Frame clock pin output enable |
| mclk_o | output | 1 | Master clock output, half the internal clock rate |

## Verification
Two events can land in the same cycle: the frame wrap (n mod 256 = 255) and either a ratio request or a loss of lock. The bench follows the frame count in its own model and steps to exactly the wrap cycle before it changes `bclk64_sel` or drops `pll_locked`. It also makes the same changes in the middle of a frame for comparison. Each sample is compared with the value the model predicts. In the coincident case this shows whether the new ratio applies from the next frame, or whether the stop wins over the wrap and the next lock restarts at n = 0.

// File: rtl/acg_pkg.sv
// Shared types for the audio clock generator.
package acg_pkg;
    // Active bit clock ratio: 64 or 32 bit clocks per frame.
    typedef enum logic {
        RATIO_32X = 1'b0,
        RATIO_64X = 1'b1
    } bclk_ratio_e;
endpackage

// File: rtl/acg_frame_counter.sv
// Frame position counter.
// Counts internal clock cycles within one frame while run is high. The
// first cycle after run rises is always position 0, so the clocks derived
// from it start with a full period. Any cycle with run low clears it.
// Assumes run is synchronous to clk.
module acg_frame_counter #(
    parameter int FRAME_LOG = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    output logic [FRAME_LOG-1:0] cnt,
    output logic                 counting,
    output logic                 frame_end
);
    localparam logic [FRAME_LOG-1:0] LAST = {FRAME_LOG{1'b1}};

    logic running_q;

    // Remember whether the previous cycle was already running.
    always_ff @(posedge clk) begin
        if (!rst_n) running_q <= 1'b0;
        else        running_q <= run;
    end

    assign counting  = run && running_q;
    assign frame_end = counting && (cnt == LAST);

    // Advance the position while counting, otherwise park at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (counting) cnt <= cnt + 1'b1;
        else               cnt <= '0;
    end
endmodule

// File: rtl/acg_ratio_latch.sv
// Bit clock ratio holding register.
// Takes the requested ratio only when load is high, which is the start of
// counting or the last cycle of a frame. A mid-frame request therefore
// waits for the next frame. Resets to the 64x ratio.
module acg_ratio_latch
    import acg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_64x,
    input  logic        load,
    output bclk_ratio_e ratio
);
    // Capture the request at a permitted boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)    ratio <= RATIO_64X;
        else if (load) ratio <= req_64x ? RATIO_64X : RATIO_32X;
    end
endmodule

// File: rtl/acg_mclk_div.sv
// Master clock divider.
// Divides the internal clock by 2**DIV_LOG while enable is high and holds
// the output low otherwise. The first output value after the hold is high.
module acg_mclk_div #(
    parameter int DIV_LOG = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic mclk
);
    generate
        if (DIV_LOG == 1) begin : g_toggle
            logic tog_q;
            // Invert every edge while enabled.
            always_ff @(posedge clk) begin
                if (!rst_n || !enable) tog_q <= 1'b0;
                else                   tog_q <= ~tog_q;
            end
            assign mclk = tog_q;
        end else begin : g_count
            logic [DIV_LOG-1:0] div_q;
            // Run a binary divider while enabled, started so the MSB rises first.
            always_ff @(posedge clk) begin
                if (!rst_n || !enable) div_q <= {1'b0, {(DIV_LOG-1){1'b1}}};
                else                   div_q <= div_q + 1'b1;
            end
            assign mclk = div_q[DIV_LOG-1];
        end
    endgenerate
endmodule

// File: rtl/audio_clkgen_top.sv
// Lock-gated audio serial clock generator.
// From a clock at 2**FRAME_LOG times the sample rate it builds the bit
// clock and frame clock, which run only in master mode with power on and
// the PLL locked, and a master clock that runs whenever power is on and
// the output is enabled. The pin enables follow the role. All control
// inputs are assumed synchronous to clk.
module audio_clkgen_top
    import acg_pkg::*;
#(
    parameter int FRAME_LOG = 8,
    parameter int FAST_LOG  = 2,
    parameter int SLOW_LOG  = 3,
    parameter int MCLK_LOG  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_pll,
    input  logic pwr_dac,
    input  logic master_sel,
    input  logic bclk64_sel,
    input  logic mclk_en,
    input  logic pll_locked,
    output logic bclk_o,
    output logic bclk_oe,
    output logic lrck_o,
    output logic lrck_oe,
    output logic mclk_o
);
    localparam int FAST_BIT  = FAST_LOG - 1;
    localparam int SLOW_BIT  = SLOW_LOG - 1;
    localparam int FRAME_BIT = FRAME_LOG - 1;

    logic                 powered;
    logic                 run;
    logic [FRAME_LOG-1:0] cnt;
    logic                 counting;
    logic                 frame_end;
    bclk_ratio_e          ratio;

    // Power and run qualification.
    assign powered = pwr_pll && pwr_dac;
    assign run     = powered && master_sel && pll_locked;

    acg_frame_counter #(.FRAME_LOG(FRAME_LOG)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .cnt      (cnt),
        .counting (counting),
        .frame_end(frame_end)
    );

    acg_ratio_latch i_ratio (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_64x(bclk64_sel),
        .load   (!counting || frame_end),
        .ratio  (ratio)
    );

    acg_mclk_div #(.DIV_LOG(MCLK_LOG)) i_mclk (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(powered && mclk_en),
        .mclk  (mclk_o)
    );

    // Clock outputs taken from the frame position; all zero when parked.
    assign bclk_o  = (ratio == RATIO_64X) ? cnt[FAST_BIT] : cnt[SLOW_BIT];
    assign lrck_o  = cnt[FRAME_BIT];

    // Pin direction follows the role.
    assign bclk_oe = master_sel;
    assign lrck_oe = master_sel;
endmodule

// File: rtl/audio_clkgen_checker.sv
// Temporal checks for audio_clkgen_top, attached by bind.
module audio_clkgen_checker (
    input logic clk,
    input logic rst_n,
    input logic pwr_pll,
    input logic pwr_dac,
    input logic master_sel,
    input logic bclk64_sel,
    input logic mclk_en,
    input logic pll_locked,
    input logic bclk_o,
    input logic bclk_oe,
    input logic lrck_o,
    input logic lrck_oe,
    input logic mclk_o
);
    // R3, R7, R10: without full qualification the serial clocks are low next cycle.
    p_quiet_unqualified_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwr_pll && pwr_dac && master_sel && pll_locked) |=> (!bclk_o && !lrck_o));

    // R1: unpowered means no master clock next cycle.
    p_mclk_unpowered_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwr_pll && pwr_dac) |=> !mclk_o);

    // R8: disabled master clock stays low.
    p_mclk_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mclk_en |=> !mclk_o);

    // R9: enabled and powered master clock inverts each edge.
    p_mclk_toggles_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_pll && pwr_dac && mclk_en) |=> (mclk_o != $past(mclk_o)));

    // R6: the frame clock changes only while the bit clock is low.
    p_lrck_on_bclk_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lrck_o) |-> !bclk_o);

    // R2: pin enables agree with each other and the role.
    p_oe_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_oe == lrck_oe) && (bclk_oe == master_sel));
endmodule

bind audio_clkgen_top audio_clkgen_checker i_chk (.*);

// File: tb/test_audio_clkgen_top.sv
module test_audio_clkgen_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_pll = 1'b0, pwr_dac = 1'b0, master_sel = 1'b0;
    logic bclk64_sel = 1'b1, mclk_en = 1'b0, pll_locked = 1'b0;
    logic bclk_o, bclk_oe, lrck_o, lrck_oe, mclk_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        string tag;
        logic  bclk;
        logic  lrck;
        logic  mclk;
        logic  oe;
    } exp_t;
    exp_t sb[$];

    // Bench model state
    int   ph = 0;
    bit   was_run = 1'b0;
    bit   ratio64 = 1'b1;
    logic m_mclk = 1'b0;

    always #10 clk = ~clk;

    audio_clkgen_top i_audio_clkgen_top (
        .clk(clk), .rst_n(rst_n), .pwr_pll(pwr_pll), .pwr_dac(pwr_dac),
        .master_sel(master_sel), .bclk64_sel(bclk64_sel), .mclk_en(mclk_en),
        .pll_locked(pll_locked), .bclk_o(bclk_o), .bclk_oe(bclk_oe),
        .lrck_o(lrck_o), .lrck_oe(lrck_oe), .mclk_o(mclk_o)
    );

    task automatic chk(input string tag, input string nm, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, nm, act, exp, $time);
        end
    endtask

    // Driver: one clock edge, model update from the requirements, push expectation.
    task automatic step(input string tag);
        exp_t it;
        bit run, cnting;
        @(posedge clk);
        run    = pwr_pll && pwr_dac && master_sel && pll_locked;
        cnting = run && was_run;
        if (!cnting || ph == 255) ratio64 = bclk64_sel;
        ph      = cnting ? (ph + 1) % 256 : 0;
        was_run = run;
        m_mclk  = (pwr_pll && pwr_dac && mclk_en) ? ~m_mclk : 1'b0;
        it.tag  = tag;
        it.bclk = ratio64 ? ph[1] : ph[2];
        it.lrck = ph[7];
        it.mclk = m_mclk;
        it.oe   = master_sel;
        sb.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic steps(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    // Monitor: pop and compare at the falling edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            chk(it.tag, "bclk_o", bclk_o, it.bclk);
            chk(it.tag, "lrck_o", lrck_o, it.lrck);
            chk(it.tag, "mclk_o", mclk_o, it.mclk);
            chk("R2", "bclk_oe", bclk_oe, it.oe);
            chk("R2", "lrck_oe", lrck_oe, it.oe);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        #(20 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // Reset state
        repeat (3) @(negedge clk);
        chk("R1", "reset bclk_o", bclk_o, 1'b0);
        chk("R1", "reset lrck_o", lrck_o, 1'b0);
        chk("R1", "reset mclk_o", mclk_o, 1'b0);
        chk("R2", "reset bclk_oe", bclk_oe, 1'b0);
        #1;
        rst_n = 1'b1;

        // R1: one power bit only, master, locked, master clock enabled
        master_sel = 1'b1; pll_locked = 1'b1; mclk_en = 1'b1; pwr_pll = 1'b1;
        steps("R1", 12);
        pwr_pll = 1'b0; pwr_dac = 1'b1;
        steps("R1", 12);

        // R3, R9: powered, master, no lock; master clock already toggling
        pll_locked = 1'b0; pwr_pll = 1'b1;
        steps("R3", 30);

        // R4, R5: lock with 64x ratio, run several frames
        pll_locked = 1'b1;
        steps("R4", 600);

        // R6: mid-frame request for 32x waits for the boundary
        while (ph != 100) step("R6");
        bclk64_sel = 1'b0;
        steps("R6", 500);

        // R6: request back to 64x exactly on the wrap cycle
        while (ph != 255) step("R6");
        bclk64_sel = 1'b1;
        steps("R6", 300);

        // R7: lose lock mid-frame, then relock
        while (ph != 77) step("R7");
        pll_locked = 1'b0;
        steps("R7", 20);
        pll_locked = 1'b1;
        steps("R7", 300);

        // R7: lose lock on the wrap cycle while a ratio change is pending
        while (ph != 200) step("R7");
        bclk64_sel = 1'b0;
        while (ph != 255) step("R7");
        pll_locked = 1'b0;
        steps("R7", 10);
        pll_locked = 1'b1;
        steps("R5", 300);

        // R7, R1: drop the converter power while running
        pwr_dac = 1'b0;
        steps("R7", 15);
        pwr_dac = 1'b1;
        steps("R7", 280);

        // R8: master clock disabled while running
        mclk_en = 1'b0;
        steps("R8", 40);

        // R10, R2: slave mode, locked, serial clocks released
        master_sel = 1'b0;
        steps("R10", 40);

        // R9: slave mode without lock, master clock enabled
        pll_locked = 1'b0; mclk_en = 1'b1;
        steps("R9", 40);
        mclk_en = 1'b0;
        steps("R8", 10);

        // Back to master, 32x from a fresh start
        master_sel = 1'b1; pll_locked = 1'b1; bclk64_sel = 1'b0;
        steps("R5", 400);

        @(negedge clk);
        finish_run();
    end
endmodule